// File: doc/BRIEF.md
# Residue-Corrected Pixel Output Scaler

This block turns one digital pixel's raw readout into a normalized output word. A pulse-counting pixel reports a coarse count of full charge packets, plus the time it took after integration ended to collect one more packet (the residue time). Together with the integration time, these let the block estimate the fractional packet and produce the corrected value floor(T × (C + 1) / (T + R)). Here T is the integration time, C is the coarse count and R is the residue time. T and R use the same clock-tick units.

The readout sequencer presents the three values with a one-cycle start strobe. The block first registers the product T × (C + 1) and the denominator T + R. It then runs a restoring divider that resolves one quotient bit per cycle. When the quotient is ready, the block registers the saturated 20-bit result and raises a one-cycle done strobe. While a computation is running, the busy output is high and further start strobes are dropped.

Top module: `pix_residue_scaler`

## Requirements
- R1: When T + R is nonzero, the result equals floor(T × (C + 1) / (T + R)), with C on 14 bits, R on 11 bits and T on 20 bits, all unsigned.
- R2: When T + R is nonzero, the result never exceeds C + 1.
- R3: A quotient that does not fit in 20 bits saturates to 20'hFFFFF. A zero denominator (T = 0 and R = 0) always yields 20'hFFFFF.
- R4: done is high for exactly one clock cycle per accepted request.
- R5: done rises on the 37th rising edge after the edge that accepts the start strobe.
- R6: busy is high from the cycle after acceptance until done. A start strobe seen while busy is high has no effect on the result.
- R7: While rst_n is low, the block clears result, done and busy to zero on the clock edge.
- R8: result holds its value from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe, accepted only when busy is low |
| count_in | input | 14 | Coarse pulse count C |
| resid_in | input | 11 | Residue time R in clock ticks |
| tint_in | input | 20 | Integration time T in clock ticks |
| result | output | 20 | Scaled, saturated output value |
| done | output | 1 | One-cycle strobe marking a new result |
| busy | output | 1 | High while a computation is in progress |

## Verification
The bench covers the following corner cases:
- **Full count with full integration time and no residue.** Here C + 1 is 16384. A product register one bit too narrow would lose the top bit and return a small value.
- **Largest residue over a one-tick integration time.** This checks the divider's remainder compare at its extremes. A compare that drops the shifted-in bit returns off-by-one quotients.
- **Zero integration time with zero residue.** The expected result is all ones. A design without saturation would instead return the divider's wrapped bits.
- **A second start strobe injected mid-computation.** The result must match the first request. A design that reloads operands while busy would return the second request's result.
- **Exact latency, done width and result hold.** The bench counts the edges to done and checks that done is not stretched and that result does not drift afterwards.

// File: rtl/scl_pkg.sv
// Package: shared widths and control state for the residue-corrected scaler.
// Assumes the residue field is never wider than the integration-time field.
package scl_pkg;
    localparam int CNT_W = 14;
    localparam int RES_W = 11;
    localparam int TIM_W = 20;
    localparam int OUT_W = 20;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_prod.sv
// Operand stage: on load, registers T*(C+1), T+R and C+1.
// Assumes RW <= TW, so that T+R fits in TW+1 bits.
module scl_prod #(
    parameter int CW = 14,
    parameter int RW = 11,
    parameter int TW = 20,
    localparam int PW = TW + CW + 1,
    localparam int DW = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cnt,
    input  logic [RW-1:0] res,
    input  logic [TW-1:0] tim,
    output logic [PW-1:0] prod_q,
    output logic [DW-1:0] den_q,
    output logic [CW:0]   cnt1_q
);
    logic [CW:0] cnt1;

    // Count plus one, the number of packets the residue interpolates toward.
    always_comb cnt1 = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};

    // Capture the numerator, denominator and bound on an accepted request only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            den_q  <= '0;
            cnt1_q <= '0;
        end else if (load) begin
            prod_q <= PW'(tim) * PW'(cnt1);
            den_q  <= DW'(tim) + DW'(res);
            cnt1_q <= cnt1;
        end
    end
endmodule

// File: rtl/scl_rdiv.sv
// Restoring divider: one quotient bit per cycle, MSB first, truncating.
// Takes NW cycles after go and pulses fin for one cycle.
// A zero divisor yields an all-ones quotient.
module scl_rdiv #(
    parameter int NW = 35,
    parameter int DW = 21,
    localparam int CNTW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          fin,
    output logic [NW-1:0] quo
);
    logic [DW-1:0]   rem;
    logic [NW-1:0]   acc;
    logic [CNTW-1:0] cnt;
    logic            active;
    logic [DW:0]     trial;
    logic            qbit;
    logic [DW:0]     nxt_rem;

    // One restoring step: shift in the next dividend bit and try to subtract.
    always_comb begin
        trial   = {rem, acc[NW-1]};
        qbit    = (trial >= {1'b0, den});
        nxt_rem = qbit ? (trial - {1'b0, den}) : trial;
    end

    // Iterate NW steps; acc shifts out the dividend and shifts in quotient bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            acc    <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                rem    <= '0;
                acc    <= num;
                cnt    <= CNTW'(NW);
                active <= 1'b1;
            end else if (active) begin
                rem <= nxt_rem[DW-1:0];
                acc <= {acc[NW-2:0], qbit};
                cnt <= cnt - 1'b1;
                if (cnt == CNTW'(1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end

    assign quo = acc;

    // R4 support: the divider finish strobe lasts a single cycle.
    p_fin_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    // R5 support: a go accepted while idle starts a run.
    p_go_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !active) |=> active);
endmodule

// File: rtl/scl_sat.sv
// Saturation: clamps a wide quotient to the output width (all ones on overflow).
module scl_sat #(
    parameter int NW = 35,
    parameter int OW = 20
) (
    input  logic [NW-1:0] quo,
    output logic [OW-1:0] clamped
);
    logic ovf;

    // Any set bit above the output width means the value does not fit.
    always_comb begin
        ovf     = |quo[NW-1:OW];
        clamped = ovf ? {OW{1'b1}} : quo[OW-1:0];
    end
endmodule

// File: rtl/pix_residue_scaler.sv
// Top: accepts a pixel's count, residue and integration time on start,
// then returns floor(T*(C+1)/(T+R)), saturated to OW bits, with a done strobe.
// The pipeline is: operand register, NW-cycle divider, saturate and register.
// Start is ignored while busy.
module pix_residue_scaler #(
    parameter int CW = scl_pkg::CNT_W,
    parameter int RW = scl_pkg::RES_W,
    parameter int TW = scl_pkg::TIM_W,
    parameter int OW = scl_pkg::OUT_W,
    localparam int PW = TW + CW + 1,
    localparam int DW = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count_in,
    input  logic [RW-1:0] resid_in,
    input  logic [TW-1:0] tint_in,
    output logic [OW-1:0] result,
    output logic          done,
    output logic          busy
);
    import scl_pkg::*;

    scl_state_e    state;
    logic          accept;
    logic          div_go;
    logic          div_fin;
    logic [PW-1:0] prod_q;
    logic [DW-1:0] den_q;
    logic [CW:0]   cnt1_q;
    logic [PW-1:0] quo;
    logic [OW-1:0] clamped;

    // Request acceptance and divider launch decode.
    always_comb begin
        accept = start && (state == ST_IDLE);
        div_go = (state == ST_MUL);
        busy   = (state != ST_IDLE);
    end

    scl_prod #(.CW(CW), .RW(RW), .TW(TW)) prod_i (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .cnt(count_in), .res(resid_in), .tim(tint_in),
        .prod_q(prod_q), .den_q(den_q), .cnt1_q(cnt1_q)
    );

    scl_rdiv #(.NW(PW), .DW(DW)) div_i (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .num(prod_q), .den(den_q), .fin(div_fin), .quo(quo)
    );

    scl_sat #(.NW(PW), .OW(OW)) sat_i (
        .quo(quo), .clamped(clamped)
    );

    // Sequence control, result register and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (accept) state <= ST_MUL;
                ST_MUL:  state <= ST_DIV;
                ST_DIV: if (div_fin) begin
                    result <= clamped;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: done never lasts two cycles.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: an accepted request makes the block busy on the next cycle.
    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R6: a start while busy leaves the captured operands untouched.
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(prod_q) && $stable(den_q)));
    // R8: result changes only together with done.
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(result)));
    // R2: with a nonzero denominator the result cannot exceed C+1.
    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_q != '0) |-> ({{(CW+1){1'b0}}, result} <= {{OW{1'b0}}, cnt1_q}));
    // R3: a zero denominator produces all ones.
    p_zero_den_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_q == '0) |-> (result == {OW{1'b1}}));
endmodule

// File: tb/pix_residue_scaler_tb.sv
// Bench: directed corners plus seeded random requests, checked against a
// reference function computed here from the requirements.
module pix_residue_scaler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [13:0] count_in = '0;
    logic [10:0] resid_in = '0;
    logic [19:0] tint_in = '0;
    logic [19:0] result;
    logic        done;
    logic        busy;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pix_residue_scaler dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .count_in(count_in), .resid_in(resid_in), .tint_in(tint_in),
        .result(result), .done(done), .busy(busy)
    );

    function automatic longint ref_out(longint c, longint r, longint t);
        longint n = t * (c + 1);
        longint d = t + r;
        longint q;
        if (d == 0) return 64'hFFFFF;
        q = n / d;
        if (q > 64'hFFFFF) q = 64'hFFFFF;
        return q;
    endfunction

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one request; optionally inject a second start mid-run (R6).
    task automatic run(longint c, longint r, longint t, bit inject);
        longint exp = ref_out(c, r, t);
        int lat = 0;
        @(negedge clk);
        start = 1'b1; count_in = c[13:0]; resid_in = r[10:0]; tint_in = t[19:0];
        @(posedge clk);
        #1;
        start = 1'b0;
        check("R6 busy after accept", busy, 1);
        while (!done && lat < 200) begin
            if (inject && lat == 10) begin
                start = 1'b1; count_in = ~c[13:0]; resid_in = 11'd3; tint_in = ~t[19:0];
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            lat++;
            #1;
        end
        start = 1'b0;
        check("R5 latency", lat, 37);
        check("R1 R3 result", result, exp);
        if (t + r != 0) check("R2 bound", (result <= c + 1), 1);
        @(posedge clk);
        #1;
        check("R4 done one cycle", done, 0);
        check("R8 result held", result, exp);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset result", result, 0);
        check("R7 reset done", done, 0);
        check("R7 reset busy", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run(0, 0, 1, 0);               // R1 minimal
        run(16383, 0, 20'hFFFFF, 0);   // R1 widest product
        run(16383, 2047, 1, 0);        // R1 largest residue
        run(5, 1, 3, 0);               // R1 truncation
        run(77, 9, 0, 0);              // R1 zero time
        run(0, 0, 0, 0);               // R3 zero denominator
        run(1000, 100, 50000, 1);      // R6 start ignored while busy
        for (int i = 0; i < 40; i++) begin
            run($urandom % 16384, $urandom % 2048, $urandom % 1048576, (i % 5) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule